// File: doc/BRIEF.md
# Tick Compare and Interrupt Control Registers

This block is the set of privileged control registers that a 64-bit processor core uses for timer interrupts and hypervisor state. It keeps a free-running tick counter, a supervisor compare register and a hypervisor compare register. When the counter reaches the value held in an armed compare register, the block latches a pending bit and raises a level interrupt request. Software reaches every register through a single-cycle register bus: a select, a write enable, an address, write data and combinational read data.

The soft-interrupt register can be written directly, or through two write-only aliases. One alias ORs the written bits in and the other clears them. The block also holds the hypervisor trap-base register, a read-only version word, the hypervisor processor-state register and eight mailbox-queue pointer registers. Any access the map does not allow has no effect and raises a one-cycle error flag. Deciding priority against the processor interrupt level and delivering the trap are left to the core.

Top module: `tick_irq_unit`

## Requirements
- R1: After reset the soft-interrupt register and the hypervisor pending bit are zero and both interrupt outputs are low. Both compare registers reset to 0x8000_0000_0000_0000, which is disarmed. The processor-state register resets with only its identifier bit (bit 11) set.
- R2: The tick counter (address 0) increases by exactly one every clock, and its bit 63 always reads zero. Writes to it are not accepted.
- R3: The supervisor compare register (address 4) reads back the value written to it. When bit 63 of that register is clear and bits 62:0 of the counter equal bits 62:0 of the register, bit 16 of the soft-interrupt register (address 1) is set on the next clock edge.
- R4: A compare register with bit 63 set never produces a match, for either the supervisor or the hypervisor compare.
- R5: When the hypervisor compare register (address 5) is armed and its bits 62:0 equal the counter, the pending bit (bit 0 of address 6) is set to 1 and `hyp_irq` rises. The soft-interrupt register is not touched. Writing 0 to address 6 clears the pending bit and drops `hyp_irq`.
- R6: A write to address 2 ORs the write data into the soft-interrupt register. Reads of address 1, 2 or 3 all return that register.
- R7: A write to address 3 clears every soft-interrupt bit that is 1 in the write data and leaves all other bits unchanged. A direct write to address 1 replaces the whole register. If a match happens in the same cycle as one of these writes, the match bit is still set.
- R8: `soft_irq` is high exactly while the soft-interrupt register is nonzero.
- R9: The trap-base register (address 7) stores and returns its written value with bits 14:0 forced to zero.
- R10: The version register (address 8) reads 0x030608: register-window count 8 in bits 7:0, maximum trap level 6 in bits 15:8 and maximum global level 3 in bits 23:16. A write to it changes nothing.
- R11: Every write to the processor-state register (address 9) stores the written value with bit 11 forced to 1.
- R12: Addresses 16 to 23 are eight independent 64-bit mailbox pointer registers: head then tail for the CPU queue, the device queue, the resumable-error queue and the non-resumable-error queue, in that order.
- R13: `bus_err` is high for exactly one cycle after any access to an unmapped address (10 to 15, 24 to 31) and after any write to address 0 or 8. Such an access changes no register, and a read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| soft_irq | output | 1 | Level request: soft-interrupt register nonzero |
| hyp_irq | output | 1 | Level request: hypervisor compare match pending |
| bus_err | output | 1 | One-cycle pulse after a disallowed access |

## Verification
The hard case to reach from the ports is a compare match, because the counter keeps running and cannot be written. The bench first reads the counter, then programs a compare value a fixed number of cycles ahead. Before that point it confirms the interrupt is still low, and after waiting past it confirms the pending bit has been set. The same sequence is repeated with bit 63 set, to show that a disarmed compare register stays silent while the counter passes the value.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int XW       = 64;
  localparam int AW       = 5;
  localparam int MBOX_N   = 8;
  localparam int MBOX_IW  = $clog2(MBOX_N);

  typedef logic [XW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;

  localparam addr_t A_TICK     = 5'd0;
  localparam addr_t A_SOFT     = 5'd1;
  localparam addr_t A_SOFT_SET = 5'd2;
  localparam addr_t A_SOFT_CLR = 5'd3;
  localparam addr_t A_SUP_CMP  = 5'd4;
  localparam addr_t A_HYP_CMP  = 5'd5;
  localparam addr_t A_HPEND    = 5'd6;
  localparam addr_t A_HTBA     = 5'd7;
  localparam addr_t A_HVER     = 5'd8;
  localparam addr_t A_HPSTATE  = 5'd9;
  localparam logic [AW-MBOX_IW-1:0] MBOX_TAG = 2'b10;

  // Armed compare (bit 63 clear) whose low 63 bits equal the counter.
  function automatic logic cmp_hit(word_t cnt, word_t cmp);
    return !cmp[XW-1] && (cnt[XW-2:0] == cmp[XW-2:0]);
  endfunction

  // Zero the n lowest bits.
  function automatic word_t clr_low(word_t v, int unsigned n);
    word_t keep;
    keep = {XW{1'b1}} << n;
    return v & keep;
  endfunction

  function automatic word_t ver_word(int unsigned nw, int unsigned tl, int unsigned gl);
    return word_t'(nw[7:0]) | (word_t'(tl[7:0]) << 8) | (word_t'(gl[7:0]) << 16);
  endfunction

  function automatic logic in_mbox(addr_t a);
    return a[AW-1:MBOX_IW] == MBOX_TAG;
  endfunction
endpackage

// File: rtl/tick_counter.sv
module tick_counter
  import tick_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output word_t cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= {1'b0, cnt[XW-2:0] + 1'b1};
  end
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit
  import tick_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_val,
  input  word_t cnt,
  output word_t cmp_q,
  output logic  hit
);
  localparam word_t DISARMED = word_t'(1) << (XW-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= DISARMED;
    else if (load) cmp_q <= load_val;
  end

  assign hit = cmp_hit(cnt, cmp_q);
endmodule

// File: rtl/tick_mbox_store.sv
module tick_mbox_store
  import tick_irq_pkg::*;
#(
  parameter int N  = MBOX_N,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  word_t         wdata,
  output word_t         rdata
);
  word_t slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        slot[g] <= '0;
      else if (we && idx == IW'(g))      slot[g] <= wdata;
    end
  end

  assign rdata = slot[idx];
endmodule

// File: rtl/tick_irq_unit.sv
module tick_irq_unit
  import tick_irq_pkg::*;
#(
  parameter int unsigned NWIN         = 8,
  parameter int unsigned MAX_TL       = 6,
  parameter int unsigned MAX_GL       = 3,
  parameter int unsigned SOFT_HIT_BIT = 16,
  parameter int unsigned HPS_ID_BIT   = 11,
  parameter int unsigned TBA_ZERO_W   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [XW-1:0] bus_wdata,
  output logic [XW-1:0] bus_rdata,
  output logic          soft_irq,
  output logic          hyp_irq,
  output logic          bus_err
);
  localparam word_t VER_VAL = ver_word(NWIN, MAX_TL, MAX_GL);
  localparam word_t HPS_ID  = word_t'(1) << HPS_ID_BIT;

  word_t tick_q, sup_cmp_q, hyp_cmp_q, mbox_rd;
  word_t softint_q, softint_d, htba_q, hpstate_q;
  logic  hpend_q, hpend_d;
  logic  sup_hit, hyp_hit;
  logic  wr_any, addr_known, ro_addr, err_d;

  assign wr_any = bus_sel & bus_we;

  tick_counter u_cnt (.clk(clk), .rst_n(rst_n), .cnt(tick_q));

  tick_cmp_unit u_sup (
    .clk(clk), .rst_n(rst_n),
    .load(wr_any && bus_addr == A_SUP_CMP), .load_val(bus_wdata),
    .cnt(tick_q), .cmp_q(sup_cmp_q), .hit(sup_hit)
  );

  tick_cmp_unit u_hyp (
    .clk(clk), .rst_n(rst_n),
    .load(wr_any && bus_addr == A_HYP_CMP), .load_val(bus_wdata),
    .cnt(tick_q), .cmp_q(hyp_cmp_q), .hit(hyp_hit)
  );

  tick_mbox_store #(.N(MBOX_N), .IW(MBOX_IW)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .we(wr_any && in_mbox(bus_addr)), .idx(bus_addr[MBOX_IW-1:0]),
    .wdata(bus_wdata), .rdata(mbox_rd)
  );

  // Access legality
  assign addr_known = in_mbox(bus_addr) || (bus_addr <= A_HPSTATE);
  assign ro_addr    = (bus_addr == A_TICK) || (bus_addr == A_HVER);
  assign err_d      = bus_sel & (!addr_known | (bus_we & ro_addr));

  // Soft-interrupt next state: software first, match last so it wins.
  always_comb begin
    softint_d = softint_q;
    if (wr_any && bus_addr == A_SOFT)     softint_d = bus_wdata;
    if (wr_any && bus_addr == A_SOFT_SET) softint_d = softint_q | bus_wdata;
    if (wr_any && bus_addr == A_SOFT_CLR) softint_d = softint_q & ~bus_wdata;
    if (sup_hit)                          softint_d[SOFT_HIT_BIT] = 1'b1;
  end

  always_comb begin
    hpend_d = hpend_q;
    if (wr_any && bus_addr == A_HPEND) hpend_d = bus_wdata[0];
    if (hyp_hit)                       hpend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      softint_q <= '0;
      hpend_q   <= 1'b0;
      htba_q    <= '0;
      hpstate_q <= HPS_ID;
      bus_err   <= 1'b0;
    end else begin
      softint_q <= softint_d;
      hpend_q   <= hpend_d;
      bus_err   <= err_d;
      if (wr_any && bus_addr == A_HTBA)    htba_q    <= clr_low(bus_wdata, TBA_ZERO_W);
      if (wr_any && bus_addr == A_HPSTATE) hpstate_q <= bus_wdata | HPS_ID;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_mbox(bus_addr)) begin
      bus_rdata = mbox_rd;
    end else begin
      case (bus_addr)
        A_TICK:                         bus_rdata = tick_q;
        A_SOFT, A_SOFT_SET, A_SOFT_CLR: bus_rdata = softint_q;
        A_SUP_CMP:                      bus_rdata = sup_cmp_q;
        A_HYP_CMP:                      bus_rdata = hyp_cmp_q;
        A_HPEND:                        bus_rdata = word_t'(hpend_q);
        A_HTBA:                         bus_rdata = clr_low(htba_q, TBA_ZERO_W);
        A_HVER:                         bus_rdata = VER_VAL;
        A_HPSTATE:                      bus_rdata = hpstate_q;
        default:                        bus_rdata = '0;
      endcase
    end
  end

  assign soft_irq = |softint_q;
  assign hyp_irq  = hpend_q;
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk
  import tick_irq_pkg::*;
#(
  parameter int unsigned TBA_ZERO_W = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sel,
  input logic                  we,
  input logic [AW-1:0]         addr,
  input logic [TBA_ZERO_W-1:0] rd_low,
  input logic                  err,
  input word_t                 cnt,
  input logic                  sup_hit,
  input logic                  hyp_hit,
  input logic                  soft_hit_bit,
  input logic                  hyp_irq
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt[XW-2:0] == $past(cnt[XW-2:0]) + 1'b1);  // R2
  AST_CNT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[XW-1] == 1'b0);  // R2
  AST_SUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sup_hit |=> soft_hit_bit);  // R3
  AST_HYP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_hit |=> hyp_irq);  // R5
  AST_TBA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr == A_HTBA) |-> rd_low == '0);  // R9
  AST_VER_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && addr == A_HVER) |=> err);  // R13
endmodule

bind tick_irq_unit tick_irq_chk #(.TBA_ZERO_W(TBA_ZERO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
  .rd_low(bus_rdata[TBA_ZERO_W-1:0]), .err(bus_err), .cnt(tick_q),
  .sup_hit(sup_hit), .hyp_hit(hyp_hit),
  .soft_hit_bit(softint_q[SOFT_HIT_BIT]), .hyp_irq(hyp_irq)
);

// File: tb/tick_irq_unit_bench.sv
`timescale 1ns/1ps
module tick_irq_unit_bench;
  import tick_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        soft_irq, hyp_irq, bus_err;
  logic        peek = 1'b0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  typedef struct { logic [63:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  tick_irq_unit u_tick_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .soft_irq(soft_irq), .hyp_irq(hyp_irq), .bus_err(bus_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per scoreboarded read.
  always @(negedge clk) begin
    #1;
    if (bus_sel && !bus_we && !peek) begin
      if (sb_q.size() == 0) chk("scoreboard underflow", 64'd1, 64'd0);
      else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic rd(logic [4:0] a, logic [63:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    sb_q.push_back('{exp, tag});
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic peek_rd(logic [4:0] a, output logic [63:0] v);
    @(negedge clk);
    peek = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; peek = 1'b0;
  endtask

  task automatic chk_now(string tag, logic [63:0] act, logic [63:0] exp);
    #1 chk(tag, act, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] t0, t1, t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_now("R1 soft_irq", 64'(soft_irq), 64'd0);
    chk_now("R1 hyp_irq", 64'(hyp_irq), 64'd0);
    rd(A_SOFT, 64'd0, "R1 softint");
    rd(A_SUP_CMP, 64'h8000_0000_0000_0000, "R1 sup cmp");
    rd(A_HYP_CMP, 64'h8000_0000_0000_0000, "R1 hyp cmp");
    rd(A_HPEND, 64'd0, "R1 pending");
    rd(A_HPSTATE, 64'h800, "R1 hpstate");

    // R2 counter steps by one per clock
    peek_rd(A_TICK, t0);
    peek_rd(A_TICK, t1);
    chk("R2 tick delta", t1 - t0, 64'd2);
    chk("R2 tick bit63", 64'(t1[63]), 64'd0);

    // R3 supervisor match
    peek_rd(A_TICK, t);
    wr(A_SUP_CMP, t + 64'd12);
    rd(A_SUP_CMP, t + 64'd12, "R3 cmp readback");
    chk_now("R3 no early irq", 64'(soft_irq), 64'd0);
    repeat (20) @(negedge clk);
    chk_now("R3 soft_irq after match", 64'(soft_irq), 64'd1);
    rd(A_SOFT, 64'h1_0000, "R3 match bit 16");
    wr(A_SOFT_CLR, 64'h1_0000);
    chk_now("R8 soft_irq drops", 64'(soft_irq), 64'd0);
    rd(A_SOFT, 64'd0, "R7 match bit cleared");

    // R4 disarmed compares stay silent
    peek_rd(A_TICK, t);
    wr(A_SUP_CMP, 64'h8000_0000_0000_0000 | (t + 64'd12));
    wr(A_HYP_CMP, 64'h8000_0000_0000_0000 | (t + 64'd14));
    repeat (20) @(negedge clk);
    chk_now("R4 sup disarmed", 64'(soft_irq), 64'd0);
    chk_now("R4 hyp disarmed", 64'(hyp_irq), 64'd0);
    rd(A_SOFT, 64'd0, "R4 softint untouched");

    // R5 hypervisor match
    peek_rd(A_TICK, t);
    wr(A_HYP_CMP, t + 64'd12);
    chk_now("R5 no early hyp", 64'(hyp_irq), 64'd0);
    repeat (20) @(negedge clk);
    chk_now("R5 hyp_irq", 64'(hyp_irq), 64'd1);
    chk_now("R5 soft untouched", 64'(soft_irq), 64'd0);
    rd(A_HPEND, 64'd1, "R5 pending");
    wr(A_HPEND, 64'd0);
    chk_now("R5 hyp_irq cleared", 64'(hyp_irq), 64'd0);

    // R6 / R7 / R8 aliases
    wr(A_SOFT_SET, 64'h5);
    chk_now("R8 soft_irq on set", 64'(soft_irq), 64'd1);
    wr(A_SOFT_SET, 64'h100);
    rd(A_SOFT, 64'h105, "R6 set alias OR");
    rd(A_SOFT_SET, 64'h105, "R6 alias read");
    wr(A_SOFT_CLR, 64'h101);
    rd(A_SOFT_CLR, 64'h4, "R7 clear alias");
    wr(A_SOFT_CLR, 64'h4);
    chk_now("R8 soft_irq zero", 64'(soft_irq), 64'd0);
    wr(A_SOFT, 64'hA0);
    rd(A_SOFT, 64'hA0, "R7 direct write");
    wr(A_SOFT, 64'd0);

    // R9 trap base
    wr(A_HTBA, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_HTBA, 64'hFFFF_FFFF_FFFF_8000, "R9 low bits zero");

    // R10 version, R13 error pulse on write
    rd(A_HVER, 64'h0003_0608, "R10 version");
    wr(A_HVER, 64'h1234);
    chk_now("R13 err after ver write", 64'(bus_err), 64'd1);
    @(negedge clk);
    chk_now("R13 err one cycle", 64'(bus_err), 64'd0);
    rd(A_HVER, 64'h0003_0608, "R10 version unchanged");

    // R11 identifier bit forced
    wr(A_HPSTATE, 64'd0);
    rd(A_HPSTATE, 64'h800, "R11 id forced");
    wr(A_HPSTATE, 64'h5);
    rd(A_HPSTATE, 64'h805, "R11 id with data");

    // R12 mailbox registers
    for (int i = 0; i < 8; i++)
      wr(5'(16 + i), 64'hA5A5_0000_0000_0000 | 64'(i * 3 + 1));
    for (int i = 0; i < 8; i++)
      rd(5'(16 + i), 64'hA5A5_0000_0000_0000 | 64'(i * 3 + 1), "R12 mailbox");

    // R13 unmapped accesses
    wr(5'd12, 64'hDEAD);
    chk_now("R13 err unmapped write", 64'(bus_err), 64'd1);
    rd(5'd12, 64'd0, "R13 unmapped read zero");
    chk_now("R13 err unmapped read", 64'(bus_err), 64'd1);
    wr(5'd28, 64'hBEEF);
    rd(5'd16, 64'hA5A5_0000_0000_0001, "R13 mailbox untouched");
    wr(A_TICK, 64'd0);
    chk_now("R13 err tick write", 64'(bus_err), 64'd1);
    peek_rd(A_TICK, t);
    chk("R13 tick not reloaded", 64'(t > 64'd100), 64'd1);
    rd(A_SOFT, 64'd0, "R13 softint untouched");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 64'(sb_q.size()), 64'd0);
    finish_run();
  end
endmodule